// File: doc/BRIEF.md
# Binary/Gray Mode-Selectable Counter

A synchronous 3-bit counter with one state register and two successor orderings. A mode input, sampled on every rising clock edge, picks which ordering supplies the next value. With mode low the counter steps through natural binary order. With mode high it steps through the reflected Gray order, so exactly one bit changes per step, including the wrap.

The mode may change on any cycle. The counter never restarts when the mode flips. The next value is always the present value's successor in whichever ordering is selected at that edge. An enable input freezes the count, and a synchronous active-low reset clears it. The block suits position trackers or test sequencers that must switch between a plain count and a single-bit-change count without losing their place.

Top module: `modesel_counter`

## Requirements
- R1: When rst_n is low at a rising clock edge, count becomes 000 after that edge, whatever en and mode are.
- R2: When rst_n is high and en is low at a rising edge, count keeps its value, whatever mode is.
- R3: When rst_n and en are high and mode is 0 (binary), count becomes (count + 1) mod 8, so 111 is followed by 000.
- R4: When rst_n and en are high and mode is 1 (Gray), count follows the cycle 000→001→011→010→110→111→101→100→000.
- R5: mode is sampled at each edge. A change of mode never clears the count, and the next value is the successor of the present value in the newly selected ordering.
- R6: In Gray mode every enabled step changes exactly one bit of count, including the step from 100 to 000.
- R7: Reset takes priority over en and mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable; when low, count holds |
| mode | input | 1 | Ordering select: 0 binary, 1 Gray |
| count | output | 3 | Present counter state |

## Verification
The bench reaches each of the eight states and then steps once in each mode. This catches a design that interprets the present value in the wrong ordering after a switch. Such a design might convert the state between codes or restart at 000, and it would give, for example, 011→010 in binary mode instead of 011→100.

The wraps 111→000 in binary and 100→000 in Gray are checked separately, because an incomplete successor table or a carry handled wrongly would stick or jump there. Holding with en low in both modes exposes a design that lets mode leak into the hold path. Asserting reset together with enable exposes a design that gives enable priority over reset.

// File: rtl/modesel_counter_pkg.sv
// Package: shared types and sizing for the mode-selectable counter.
// Assumes: nothing beyond IEEE 1800-2017.
package modesel_counter_pkg;

    // Default counter width; the orderings are defined for any width >= 2.
    localparam int unsigned CNT_W_DEFAULT = 3;

    // Ordering select carried on the mode pin.
    typedef enum logic {
        ORDER_BINARY = 1'b0,
        ORDER_GRAY   = 1'b1
    } order_e;

endpackage

// File: rtl/modesel_bin_next.sv
// Module: binary successor. Gives (cur + 1) modulo 2**W.
// Assumes: cur is a plain unsigned value; the wrap comes from truncation.
module modesel_bin_next #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    // Purpose: increment with natural wrap from all-ones to zero.
    always_comb begin
        nxt = cur + W'(1);
    end

endmodule

// File: rtl/modesel_gray_next.sv
// Module: reflected-Gray successor. Decodes cur to binary with a prefix
// XOR, increments, and re-encodes.
// Assumes: cur holds a valid reflected Gray code word (every W-bit word is one).
module modesel_gray_next #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    logic [W-1:0] as_bin;
    logic [W-1:0] bin_inc;

    // Purpose: Gray-to-binary decode; bit i is the XOR of bits W-1 down to i.
    for (genvar i = 0; i < W; i++) begin : g_decode
        assign as_bin[i] = ^cur[W-1:i];
    end

    // Purpose: advance the rank and re-encode it as Gray.
    always_comb begin
        bin_inc = as_bin + W'(1);
        nxt     = bin_inc ^ (bin_inc >> 1);
    end

endmodule

// File: rtl/modesel_counter.sv
// Module: mode-selectable counter top. One state register; at each enabled
// edge it loads the binary or the Gray successor of its present value,
// as chosen by mode at that edge.
// Assumes: rst_n is synchronous, active low, and has priority over en.
module modesel_counter
    import modesel_counter_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         mode,
    output logic [W-1:0] count
);

    logic [W-1:0] state_q;
    logic [W-1:0] succ_bin;
    logic [W-1:0] succ_gray;
    logic [W-1:0] succ_sel;
    order_e       order_sel;

    modesel_bin_next #(.W(W)) u_bin_next (
        .cur (state_q),
        .nxt (succ_bin)
    );

    modesel_gray_next #(.W(W)) u_gray_next (
        .cur (state_q),
        .nxt (succ_gray)
    );

    // Purpose: pick the successor for the ordering selected this cycle.
    always_comb begin
        order_sel = order_e'(mode);
        succ_sel  = (order_sel == ORDER_GRAY) ? succ_gray : succ_bin;
    end

    // Purpose: state register with synchronous reset and hold on !en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (en) begin
            state_q <= succ_sel;
        end
    end

    assign count = state_q;

    // R1 / R7
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    // R3
    binary_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode) |=> (count == W'($past(count) + W'(1))));

    // R6
    gray_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode) |=> ($countones(count ^ $past(count)) == 1));

endmodule

// File: tb/modesel_counter_bench.sv
module modesel_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         mode = 1'b0;
    logic [W-1:0] count;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    modesel_counter u_modesel_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .mode  (mode),
        .count (count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {rst_n, en, mode, expected count, requirement number}
    localparam int NV = 37;
    localparam logic [8:0] VECS [0:NV-1] = '{
        {3'b000, 3'd0, 3'd1},                      // R1 reset
        {3'b110, 3'd1, 3'd3}, {3'b110, 3'd2, 3'd3}, // R3 binary walk
        {3'b110, 3'd3, 3'd3}, {3'b110, 3'd4, 3'd3},
        {3'b110, 3'd5, 3'd3}, {3'b110, 3'd6, 3'd3},
        {3'b110, 3'd7, 3'd3}, {3'b110, 3'd0, 3'd3}, // R3 wrap
        {3'b111, 3'd1, 3'd4}, {3'b111, 3'd3, 3'd4}, // R4 Gray walk
        {3'b111, 3'd2, 3'd4}, {3'b111, 3'd6, 3'd4},
        {3'b111, 3'd7, 3'd4}, {3'b111, 3'd5, 3'd4},
        {3'b111, 3'd4, 3'd4}, {3'b111, 3'd0, 3'd6}, // R6 wrap 100->000
        {3'b111, 3'd1, 3'd4}, {3'b111, 3'd3, 3'd4},
        {3'b110, 3'd4, 3'd5},                      // R5 Gray->binary from 011
        {3'b111, 3'd0, 3'd5},                      // R5 binary->Gray from 100
        {3'b111, 3'd1, 3'd4},
        {3'b110, 3'd2, 3'd5},
        {3'b111, 3'd6, 3'd5},
        {3'b110, 3'd7, 3'd5},
        {3'b111, 3'd5, 3'd5},
        {3'b101, 3'd5, 3'd2}, {3'b100, 3'd5, 3'd2}, // R2 hold both modes
        {3'b100, 3'd5, 3'd2}, {3'b101, 3'd5, 3'd2},
        {3'b110, 3'd6, 3'd3},
        {3'b011, 3'd0, 3'd7},                      // R7 reset beats enable
        {3'b111, 3'd1, 3'd4},
        {3'b010, 3'd0, 3'd7},
        {3'b001, 3'd0, 3'd1},
        {3'b110, 3'd1, 3'd3},
        {3'b111, 3'd3, 3'd4}
    };

    // Gray ordering position table, taken from R4
    function automatic logic [W-1:0] gray_succ(input logic [W-1:0] s);
        case (s)
            3'b000: return 3'b001;
            3'b001: return 3'b011;
            3'b011: return 3'b010;
            3'b010: return 3'b110;
            3'b110: return 3'b111;
            3'b111: return 3'b101;
            3'b101: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check(input logic [W-1:0] exp, input int req, input string what);
        n_checks++;
        if (count !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: count=%b expected=%b", req, what, count, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic m);
        rst_n = r; en = e; mode = m;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1;
        // Table walk
        for (int i = 0; i < NV; i++) begin
            step(VECS[i][8], VECS[i][7], VECS[i][6]);
            check(VECS[i][5:3], int'(VECS[i][2:0]), $sformatf("vector %0d", i));
        end

        // R5: from every state, one step in each ordering
        for (int s = 0; s < 8; s++) begin
            for (int m = 0; m < 2; m++) begin
                step(1'b0, 1'b0, 1'b0);
                for (int k = 0; k < s; k++) step(1'b1, 1'b1, 1'b0);
                check(W'(s), 3, "reach start state in binary");
                step(1'b1, 1'b1, m[0]);
                check(m[0] ? gray_succ(W'(s)) : W'(s + 1), 5,
                      $sformatf("switch step from %0d mode %0d", s, m));
            end
        end

        // R6: full Gray lap, one-bit change each step
        step(1'b0, 1'b1, 1'b1);
        check(3'b000, 1, "reset before Gray lap");
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0] prev;
            prev = count;
            step(1'b1, 1'b1, 1'b1);
            n_checks++;
            if ($countones(prev ^ count) != 1) begin
                n_fails++;
                $display("FAIL R6 bits changed %0d expected 1 (%b->%b)",
                         $countones(prev ^ count), prev, count);
            end
        end

        // R7: reset with en high and mode Gray mid-count
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        check(3'b000, 7, "reset over enable");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired: done=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule